// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Match Alarm

This block keeps a 32-bit count of elapsed seconds behind a small word-addressed register port. A one-cycle strobe on `tick`, produced elsewhere once per second, advances the count while the run bit in the control register is set. Software sets the time by writing a preload value. That value is not visible at once. It is copied into the count on the next enabled tick, in place of that tick's increment.

An alarm compare value is held alongside the count. When the value the count takes on an enabled tick equals the compare value, a sticky raw event flag is set. Two control bits, an enable and a mask, gate that flag onto the `irq` output and onto a masked status view. Software acknowledges the event by reading an acknowledge offset. The read alone clears the flag, so no write is needed. A further control bit picks where the count goes after its all-ones value: back to zero, or to the compare value.

Top module: `sec_rtc`

## Requirements
- R1: While reset is low and after it is released, the count, compare value, preload value, control bits and raw event flag read zero, and `irq` is low.
- R2: Byte offsets are fixed: count 0x00, compare 0x04 (read/write), preload 0x08 (read/write), control 0x0C (bits [3:0] read/write, upper bits read 0), masked status 0x10, raw status 0x14, acknowledge 0x18 (reads 0), version 0x1C. Writes to 0x00, 0x10, 0x14, 0x18 and 0x1C change no state. Any other offset reads 0.
- R3: Control bit 2 is the run bit. On a tick with the run bit set, the count grows by one. A tick with the run bit clear leaves the count unchanged.
- R4: A write to the preload offset leaves the readable count unchanged until the next tick with the run bit set. On that tick the count takes the preloaded value instead of incrementing. Later ticks increment again.
- R5: With control bit 3 clear, an enabled tick at count 0xFFFFFFFF gives 0.
- R6: With control bit 3 set, an enabled tick at count 0xFFFFFFFF gives the compare value.
- R7: Raw status bit 0 (offset 0x14) is set by the edge that ends an enabled tick whose new count equals the compare value, whatever the enable and mask bits hold. This includes a count that comes from a preload.
- R8: The raw event flag stays set until a read of offset 0x18 and is clear from the next cycle on. If a compare hit happens in the same cycle as that read, the flag stays set.
- R9: `irq` and masked status bit 0 (offset 0x10) are 1 exactly when the raw flag is set, control bit 0 (enable) is 1 and control bit 1 (mask) is 0.
- R10: Offset 0x1C reads the constant parameter `VERSION` (default 0x00010300).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle once-per-second strobe |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed only for the acknowledge side effect) |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Gated alarm interrupt |

## Verification
The assertions assume that `tick` is a single-cycle pulse synchronous to `clk`. They also assume that a preload write never lands in the same cycle as an enabled tick, and that the count only changes through the strobes issued by the control side. The stimulus drives every input on the falling edge, holds each strobe for exactly one cycle, and keeps preload writes and ticks in separate cycles. The one deliberate collision, a compare hit together with an acknowledge read, exercises the rule that the hit takes precedence.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int MAP_ADDR_W = 5;
  localparam logic [MAP_ADDR_W-1:0] OFS_COUNT = 5'h00;
  localparam logic [MAP_ADDR_W-1:0] OFS_MATCH = 5'h04;
  localparam logic [MAP_ADDR_W-1:0] OFS_LOAD  = 5'h08;
  localparam logic [MAP_ADDR_W-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [MAP_ADDR_W-1:0] OFS_STAT  = 5'h10;
  localparam logic [MAP_ADDR_W-1:0] OFS_RAW   = 5'h14;
  localparam logic [MAP_ADDR_W-1:0] OFS_ACK   = 5'h18;
  localparam logic [MAP_ADDR_W-1:0] OFS_VER   = 5'h1C;

  localparam int CTRL_W  = 4;
  localparam int CB_IE   = 0;
  localparam int CB_MASK = 1;
  localparam int CB_RUN  = 2;
  localparam int CB_WRAP = 3;

  typedef struct packed {
    logic advance;
    logic useLoad;
    logic wrapToMatch;
  } cntStrobe_t;
endpackage

// File: rtl/sec_rtc_dp.sv
module sec_rtc_dp
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        stb,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] matchVal,
  output logic [DATA_W-1:0] countVal,
  output logic              hit
);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] countNext;

  always_comb begin
    countNext = countQ;
    if (stb.advance) begin
      if (stb.useLoad) begin
        countNext = loadVal;
      end else if (countQ == CNT_MAX) begin
        countNext = stb.wrapToMatch ? matchVal : '0;
      end else begin
        countNext = countQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else begin
      countQ <= countNext;
    end
  end

  assign countVal = countQ;
  assign hit      = stb.advance && (countNext == matchVal);
endmodule

// File: rtl/sec_rtc_ctrl.sv
module sec_rtc_ctrl
  import sec_rtc_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter int              ADDR_W  = 5,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] countVal,
  input  logic              hit,
  output cntStrobe_t        stb,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] matchVal,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic              rawPend,
  output logic              loadPend,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [DATA_W-1:0] matchQ;
  logic [DATA_W-1:0] loadQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic              pendQ;
  logic              rawQ;
  logic              stepNow;
  logic              gatedEvt;
  logic              selMatch, selLoad, selCtrl, selAck;

  assign selMatch = (addr == ADDR_W'(OFS_MATCH));
  assign selLoad  = (addr == ADDR_W'(OFS_LOAD));
  assign selCtrl  = (addr == ADDR_W'(OFS_CTRL));
  assign selAck   = (addr == ADDR_W'(OFS_ACK));

  assign stepNow  = tick && ctrlQ[CB_RUN];
  assign gatedEvt = rawQ && ctrlQ[CB_IE] && !ctrlQ[CB_MASK];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchQ <= '0;
      loadQ  <= '0;
      ctrlQ  <= '0;
      pendQ  <= 1'b0;
      rawQ   <= 1'b0;
    end else begin
      if (wrEn && selMatch) matchQ <= wrData;
      if (wrEn && selCtrl)  ctrlQ  <= wrData[CTRL_W-1:0];
      if (wrEn && selLoad) begin
        loadQ <= wrData;
        pendQ <= 1'b1;
      end else if (stepNow) begin
        pendQ <= 1'b0;
      end
      if (hit) begin
        rawQ <= 1'b1;
      end else if (rdEn && selAck) begin
        rawQ <= 1'b0;
      end
    end
  end

  always_comb begin
    stb             = '0;
    stb.advance     = stepNow;
    stb.useLoad     = pendQ;
    stb.wrapToMatch = ctrlQ[CB_WRAP];
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_W'(OFS_COUNT): rdData = countVal;
      ADDR_W'(OFS_MATCH): rdData = matchQ;
      ADDR_W'(OFS_LOAD):  rdData = loadQ;
      ADDR_W'(OFS_CTRL):  rdData = DATA_W'(ctrlQ);
      ADDR_W'(OFS_STAT):  rdData = DATA_W'(gatedEvt);
      ADDR_W'(OFS_RAW):   rdData = DATA_W'(rawQ);
      ADDR_W'(OFS_VER):   rdData = VERSION;
      default:            rdData = '0;
    endcase
  end

  assign loadVal  = loadQ;
  assign matchVal = matchQ;
  assign ctrlBits = ctrlQ;
  assign rawPend  = rawQ;
  assign loadPend = pendQ;
  assign irq      = gatedEvt;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter int                ADDR_W  = 5,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  cntStrobe_t        stb;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] matchVal;
  logic [CTRL_W-1:0] ctrlBits;
  logic              hit;
  logic              rawPend;
  logic              loadPend;

  sec_rtc_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .VERSION(VERSION)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrData  (wrData),
    .countVal(countVal),
    .hit     (hit),
    .stb     (stb),
    .loadVal (loadVal),
    .matchVal(matchVal),
    .ctrlBits(ctrlBits),
    .rawPend (rawPend),
    .loadPend(loadPend),
    .rdData  (rdData),
    .irq     (irq)
  );

  sec_rtc_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .loadVal (loadVal),
    .matchVal(matchVal),
    .countVal(countVal),
    .hit     (hit)
  );
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              irq,
  input logic [DATA_W-1:0] countVal,
  input logic [CTRL_W-1:0] ctrlBits,
  input logic              rawPend,
  input logic              loadPend
);
  logic runTick;
  logic ackRead;
  assign runTick = tick && ctrlBits[CB_RUN];
  assign ackRead = rdEn && (addr == ADDR_W'(OFS_ACK));

  // R3 R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runTick |=> $stable(countVal));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    runTick && !loadPend && (countVal != '1) |=> countVal == DATA_W'($past(countVal) + 1'b1));

  // R8
  raw_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rawPend && !ackRead |=> rawPend);

  // R8
  raw_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackRead && !runTick |=> !rawPend);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rawPend && ctrlBits[CB_IE] && !ctrlBits[CB_MASK]);
endmodule

bind sec_rtc sec_rtc_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .rdEn    (rdEn),
  .addr    (addr),
  .irq     (irq),
  .countVal(countVal),
  .ctrlBits(ctrlBits),
  .rawPend (rawPend),
  .loadPend(loadPend)
);

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h0001_0300;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_TK = 3'd2, OP_EO = 3'd3, OP_IQ = 3'd4;
  localparam int NV = 40;

  // {req[3:0], op[2:0], addr[4:0], data[31:0], exp[31:0]}
  localparam logic [75:0] VECS [0:NV-1] = '{
    {4'd1,  OP_RD, 5'h00, 32'd0,   32'd0},   // R1 count
    {4'd1,  OP_RD, 5'h0C, 32'd0,   32'd0},   // R1 control
    {4'd1,  OP_RD, 5'h14, 32'd0,   32'd0},   // R1 raw
    {4'd1,  OP_IQ, 5'h00, 32'd0,   32'd0},   // R1 irq
    {4'd3,  OP_WR, 5'h0C, 32'd4,   32'd0},
    {4'd3,  OP_TK, 5'h00, 32'd0,   32'd0},
    {4'd3,  OP_RD, 5'h00, 32'd0,   32'd1},   // R3 step
    {4'd3,  OP_WR, 5'h0C, 32'd0,   32'd0},
    {4'd3,  OP_TK, 5'h00, 32'd0,   32'd0},
    {4'd3,  OP_RD, 5'h00, 32'd0,   32'd1},   // R3 halted
    {4'd4,  OP_WR, 5'h0C, 32'd4,   32'd0},
    {4'd4,  OP_WR, 5'h08, 32'd100, 32'd0},
    {4'd4,  OP_RD, 5'h00, 32'd0,   32'd1},   // R4 not yet visible
    {4'd2,  OP_RD, 5'h08, 32'd0,   32'd100}, // R2 preload readback
    {4'd4,  OP_TK, 5'h00, 32'd0,   32'd0},
    {4'd4,  OP_RD, 5'h00, 32'd0,   32'd100}, // R4 taken
    {4'd4,  OP_TK, 5'h00, 32'd0,   32'd0},
    {4'd4,  OP_RD, 5'h00, 32'd0,   32'd101}, // R4 increments again
    {4'd2,  OP_WR, 5'h04, 32'd103, 32'd0},
    {4'd2,  OP_RD, 5'h04, 32'd0,   32'd103}, // R2 compare readback
    {4'd7,  OP_TK, 5'h00, 32'd0,   32'd0},
    {4'd7,  OP_RD, 5'h14, 32'd0,   32'd0},   // R7 no hit at 102
    {4'd7,  OP_TK, 5'h00, 32'd0,   32'd0},
    {4'd7,  OP_RD, 5'h14, 32'd0,   32'd1},   // R7 hit with enable off
    {4'd9,  OP_RD, 5'h10, 32'd0,   32'd0},   // R9 enable off
    {4'd9,  OP_WR, 5'h0C, 32'd5,   32'd0},
    {4'd9,  OP_RD, 5'h10, 32'd0,   32'd1},   // R9 enabled
    {4'd9,  OP_IQ, 5'h00, 32'd0,   32'd1},   // R9 irq high
    {4'd9,  OP_WR, 5'h0C, 32'd7,   32'd0},
    {4'd9,  OP_IQ, 5'h00, 32'd0,   32'd0},   // R9 masked
    {4'd9,  OP_WR, 5'h0C, 32'd5,   32'd0},
    {4'd8,  OP_TK, 5'h00, 32'd0,   32'd0},
    {4'd8,  OP_RD, 5'h14, 32'd0,   32'd1},   // R8 sticky
    {4'd8,  OP_EO, 5'h18, 32'd0,   32'd0},   // R8 ack reads zero
    {4'd8,  OP_RD, 5'h14, 32'd0,   32'd0},   // R8 cleared
    {4'd2,  OP_WR, 5'h00, 32'h55,  32'd0},
    {4'd2,  OP_RD, 5'h00, 32'd0,   32'd104}, // R2 count write ignored
    {4'd10, OP_WR, 5'h1C, 32'd0,   32'd0},
    {4'd10, OP_RD, 5'h1C, 32'd0,   VER},     // R10 version
    {4'd2,  OP_RD, 5'h0C, 32'd0,   32'd5}    // R2 control readback
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  int total = 0;
  int bad = 0;

  sec_rtc u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a; rdEn = 1'b0;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic tickOnce();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ackRead(input string req, input logic withTick);
    @(negedge clk);
    addr = 5'h18; rdEn = 1'b1; tick = withTick;
    #1;
    chk(req, rdData, 32'd0);
    @(negedge clk);
    rdEn = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      automatic string rq = $sformatf("R%0d", VECS[i][75:72]);
      automatic logic [4:0] va = VECS[i][68:64];
      automatic logic [31:0] vd = VECS[i][63:32];
      automatic logic [31:0] ve = VECS[i][31:0];
      case (VECS[i][71:69])
        OP_WR: busWrite(va, vd);
        OP_RD: readChk(rq, va, ve);
        OP_TK: tickOnce();
        OP_EO: ackRead(rq, 1'b0);
        default: begin
          @(negedge clk);
          #1;
          chk(rq, {31'd0, irq}, ve);
        end
      endcase
    end

    // R5: wrap to zero
    busWrite(5'h0C, 32'd4);
    busWrite(5'h08, 32'hFFFF_FFFF);
    tickOnce();
    readChk("R5", 5'h00, 32'hFFFF_FFFF);
    tickOnce();
    readChk("R5", 5'h00, 32'd0);
    readChk("R7", 5'h14, 32'd0);

    // R6: wrap to compare value, which is also a hit (R7)
    busWrite(5'h04, 32'd50);
    busWrite(5'h0C, 32'hC);
    busWrite(5'h08, 32'hFFFF_FFFF);
    tickOnce();
    readChk("R6", 5'h00, 32'hFFFF_FFFF);
    tickOnce();
    readChk("R6", 5'h00, 32'd50);
    readChk("R7", 5'h14, 32'd1);

    // R8: hit in the same cycle as the acknowledge read keeps the flag
    busWrite(5'h04, 32'd51);
    ackRead("R8", 1'b1);
    readChk("R8", 5'h00, 32'd51);
    readChk("R8", 5'h14, 32'd1);
    ackRead("R8", 1'b0);
    readChk("R8", 5'h14, 32'd0);

    // R7: hit produced by a preload
    busWrite(5'h04, 32'd900);
    busWrite(5'h08, 32'd900);
    tickOnce();
    readChk("R7", 5'h14, 32'd1);

    // R1: reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1", {31'd0, irq}, 32'd0);
    readChk("R1", 5'h00, 32'd0);
    readChk("R1", 5'h04, 32'd0);
    readChk("R1", 5'h08, 32'd0);
    readChk("R1", 5'h14, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    readChk("R1", 5'h0C, 32'd0);
    readChk("R2", 5'h0A, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule